// File: doc/BRIEF.md
# Serially Configured Crosspoint Matrix

This block models the digital behaviour of a 16-by-16 crosspoint. There are 16 column inputs and 16 row outputs, and each column-to-row intersection has one control bit. The control bits arrive as a serial stream on a three-wire interface: a data line, a serial clock and an active-low transfer strobe. Each rising serial-clock edge moves one bit into a 256-stage chain. When the strobe is released after being held low, the whole chain is copied into a bank of 256 control latches. The latches set which crosspoints are closed.

Each row output is the OR of every column input whose crosspoint to that row is closed. A row with no closed crosspoint reads 0. The last stage of the chain is brought out on a serial output, so several blocks can be daisy-chained by wiring that output to the serial data input of the next block. The serial clock, data and strobe are treated as asynchronous to the system clock. They are passed through synchronizer stages and their edges are detected in the system clock domain.

Top module: `xbar_serial_matrix`

## Requirements
- R1: After reset every control latch and every chain stage is 0, so all row outputs and the serial output read 0.
- R2: Shifting bits into the chain does not change the row outputs until a transfer occurs.
- R3: Bit order: the first bit shifted in of a 256-bit frame ends up controlling row 15 / column 15. The 16th bit controls row 15 / column 0. The 17th bit controls row 14 / column 15. The 256th bit controls row 0 / column 0.
- R4: A control value of 1 closes a crosspoint and 0 opens it. Row r equals the OR of col_in[c] over all closed crosspoints (r, c).
- R5: A transfer copies the chain into the latches on the release (low-to-high edge) of xfer_n. The latches then hold their contents through later shifting, including shifting done while xfer_n is low, until the next release.
- R6: ser_out is the last chain stage. After a full 256-bit frame it shows the first bit of that frame, and each further serial-clock rising edge advances it to the next bit of the frame. Falling serial-clock edges do not shift the chain.
- R7: One column may be connected to several rows at once, and one row may have several columns connected at once.
- R8: A row with no closed crosspoint reads 0 even when every column input is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial configuration data |
| ser_clk | input | 1 | Serial clock; each rising edge shifts one bit |
| xfer_n | input | 1 | Active-low transfer strobe; its release copies the chain into the latches |
| col_in | input | 16 | Column inputs |
| row_out | output | 16 | Row outputs, each the OR of its connected columns |
| ser_out | output | 1 | Last chain stage, for cascading |

## Verification
The hardest case to reach from the ports is a full new frame shifted in while xfer_n is held low. The latches must ignore all of that traffic and then take the newest chain contents at the single release edge. The bench holds the strobe low, shifts 256 fresh bits, and checks the rows against the old pattern. It then releases the strobe and checks the rows against the new frame. It also shifts a frame of known content one bit past full length, so that the chain tail is checked on the serial output at the frame boundary.

// File: rtl/xsm_pkg.sv
package xsm_pkg;
    localparam int unsigned XSM_COLS_DEF   = 16;
    localparam int unsigned XSM_ROWS_DEF   = 16;
    localparam int unsigned XSM_SYNC_DEF   = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    function automatic int unsigned xsm_bit_index(input int unsigned row,
                                                  input int unsigned col,
                                                  input int unsigned cols);
        return row * cols + col;
    endfunction
endpackage

// File: rtl/xsm_edge_sync.sv
module xsm_edge_sync
    import xsm_pkg::*;
#(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b0,
    parameter edge_kind_e  EDGE      = EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic pulse
);
    localparam int unsigned PIPE_W = STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.pipe = {state_q.pipe[PIPE_W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pipe <= {PIPE_W{RESET_VAL}};
        end else begin
            state_q <= state_d;
        end
    end

    logic lvl_now;
    logic lvl_prev;
    assign lvl_now  = state_q.pipe[STAGES-1];
    assign lvl_prev = state_q.pipe[STAGES];
    assign level    = lvl_now;

    generate
        if (EDGE == EDGE_RISE) begin : g_rise
            assign pulse = lvl_now & ~lvl_prev;
        end else begin : g_fall
            assign pulse = ~lvl_now & lvl_prev;
        end
    endgenerate
endmodule

// File: rtl/xsm_shift_chain.sv
module xsm_shift_chain #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_data,
    input  logic             shift_fire,
    output logic [DEPTH-1:0] chain,
    output logic             tail
);
    typedef struct packed {
        logic [STAGES-1:0] dsync;
        logic [DEPTH-1:0]  sr;
    } chain_state_t;

    chain_state_t state_d, state_q;
    logic         data_aligned;

    assign data_aligned = state_q.dsync[STAGES-1];

    always_comb begin
        state_d       = state_q;
        state_d.dsync = {state_q.dsync[STAGES-2:0], ser_data};
        if (shift_fire) begin
            state_d.sr = {state_q.sr[DEPTH-2:0], data_aligned};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.dsync <= '0;
            state_q.sr    <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign chain = state_q.sr;
    assign tail  = state_q.sr[DEPTH-1];
endmodule

// File: rtl/xsm_ctrl_latches.sv
module xsm_ctrl_latches #(
    parameter int unsigned WIDTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] ctl
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } latch_state_t;

    latch_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.bits = src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.bits <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctl = state_q.bits;
endmodule

// File: rtl/xsm_or_matrix.sv
module xsm_or_matrix #(
    parameter int unsigned COLS = 16,
    parameter int unsigned ROWS = 16
) (
    input  logic [ROWS*COLS-1:0] ctl,
    input  logic [COLS-1:0]      col_in,
    output logic [ROWS-1:0]      row_out
);
    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            logic [COLS-1:0] row_mask;
            logic [COLS-1:0] row_hits;
            always_comb begin
                row_mask   = ctl[r*COLS +: COLS];
                row_hits   = row_mask & col_in;
                row_out[r] = |row_hits;
            end
        end
    endgenerate
endmodule

// File: rtl/xbar_serial_matrix.sv
module xbar_serial_matrix
    import xsm_pkg::*;
#(
    parameter int unsigned COLS   = XSM_COLS_DEF,
    parameter int unsigned ROWS   = XSM_ROWS_DEF,
    parameter int unsigned STAGES = XSM_SYNC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_data,
    input  logic            ser_clk,
    input  logic            xfer_n,
    input  logic [COLS-1:0] col_in,
    output logic [ROWS-1:0] row_out,
    output logic            ser_out
);
    localparam int unsigned NBITS = ROWS * COLS;

    logic             sclk_level;
    logic             shift_fire;
    logic             xfer_level;
    logic             xfer_fire;
    logic [NBITS-1:0] chain_q;
    logic [NBITS-1:0] latch_q;

    xsm_edge_sync #(
        .STAGES   (STAGES),
        .RESET_VAL(1'b0),
        .EDGE     (EDGE_RISE)
    ) u_sclk_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(ser_clk),
        .level   (sclk_level),
        .pulse   (shift_fire)
    );

    xsm_edge_sync #(
        .STAGES   (STAGES),
        .RESET_VAL(1'b1),
        .EDGE     (EDGE_RISE)
    ) u_xfer_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(xfer_n),
        .level   (xfer_level),
        .pulse   (xfer_fire)
    );

    xsm_shift_chain #(
        .DEPTH (NBITS),
        .STAGES(STAGES)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_data  (ser_data),
        .shift_fire(shift_fire),
        .chain     (chain_q),
        .tail      (ser_out)
    );

    xsm_ctrl_latches #(
        .WIDTH(NBITS)
    ) u_latches (
        .clk  (clk),
        .rst_n(rst_n),
        .load (xfer_fire),
        .src  (chain_q),
        .ctl  (latch_q)
    );

    xsm_or_matrix #(
        .COLS(COLS),
        .ROWS(ROWS)
    ) u_matrix (
        .ctl    (latch_q),
        .col_in (col_in),
        .row_out(row_out)
    );

    logic unused_levels;
    assign unused_levels = sclk_level ^ xfer_level;
endmodule

// File: rtl/xbar_serial_matrix_chk.sv
module xbar_serial_matrix_chk #(
    parameter int unsigned COLS = 16,
    parameter int unsigned ROWS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 shift_fire,
    input logic                 xfer_fire,
    input logic [ROWS*COLS-1:0] chain_q,
    input logic [ROWS*COLS-1:0] latch_q,
    input logic [COLS-1:0]      col_in,
    input logic [ROWS-1:0]      row_out,
    input logic                 ser_out
);
    localparam int unsigned NBITS = ROWS * COLS;

    // R5: latches change only on a transfer event
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_fire |=> $stable(latch_q));

    // R5: a transfer takes the chain contents
    a_r5_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_fire |=> latch_q == $past(chain_q));

    // R6: chain moves only on a serial-clock rising edge
    a_r6_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_fire |=> $stable(chain_q));

    // R6: the tail follows the next-to-last stage on a shift
    a_r6_tail_advance: assert property (@(posedge clk) disable iff (!rst_n)
        shift_fire |=> ser_out == $past(chain_q[NBITS-2]));

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_rchk
            // R8: a row with nothing closed stays low
            a_r8_open_row_low: assert property (@(posedge clk) disable iff (!rst_n)
                (latch_q[r*COLS +: COLS] == '0) |-> !row_out[r]);
            // R4: all columns high and something closed drives the row high
            a_r4_closed_row_high: assert property (@(posedge clk) disable iff (!rst_n)
                ((latch_q[r*COLS +: COLS] != '0) && (&col_in)) |-> row_out[r]);
        end
    endgenerate
endmodule

bind xbar_serial_matrix xbar_serial_matrix_chk #(
    .COLS(COLS),
    .ROWS(ROWS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_fire(shift_fire),
    .xfer_fire (xfer_fire),
    .chain_q   (chain_q),
    .latch_q   (latch_q),
    .col_in    (col_in),
    .row_out   (row_out),
    .ser_out   (ser_out)
);

// File: tb/xbar_serial_matrix_test.sv
module xbar_serial_matrix_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_clk = 1'b0;
    logic        xfer_n = 1'b1;
    logic [15:0] col_in = '0;
    logic [15:0] row_out;
    logic        ser_out;

    int n_checks = 0;
    int n_fails  = 0;
    logic [255:0] cur_cfg = '0;
    logic [31:0]  lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    xbar_serial_matrix uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_data(ser_data),
        .ser_clk (ser_clk),
        .xfer_n  (xfer_n),
        .col_in  (col_in),
        .row_out (row_out),
        .ser_out (ser_out)
    );

    // Frame bit index = row*16 + col; frame[255] is shifted first.
    function automatic logic [15:0] model_rows(input logic [255:0] cfg, input logic [15:0] cols);
        logic [15:0] res = '0;
        for (int r = 0; r < 16; r++) res[r] = |(cfg[r*16 +: 16] & cols);
        return res;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b;
        wait_cyc(2);
        ser_clk = 1'b1;
        wait_cyc(4);
        ser_clk = 1'b0;
        wait_cyc(3);
    endtask

    task automatic shift_frame(input logic [255:0] f);
        for (int i = 255; i >= 0; i--) shift_bit(f[i]);
    endtask

    task automatic pulse_xfer();
        xfer_n = 1'b0;
        wait_cyc(4);
        xfer_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic check_rows(input string req, input logic [255:0] cfg, input logic [15:0] cols);
        col_in = cols;
        wait_cyc(1);
        check(req, {16'h0, row_out}, {16'h0, model_rows(cfg, cols)});
    endtask

    task automatic t_reset();
        check("R1 rows", {16'h0, row_out}, 32'h0);
        check("R1 sout", {31'h0, ser_out}, 32'h0);
        check_rows("R1 rows all cols high", '0, 16'hFFFF);
    endtask

    task automatic t_order();
        logic [255:0] f;
        f = '0; f[255] = 1'b1;
        shift_frame(f);
        check_rows("R2 no change before xfer", '0, 16'hFFFF);
        pulse_xfer();
        cur_cfg = f;
        check_rows("R3 first bit Y15X15", f, 16'h8000);
        check("R3 Y15X15 high", {31'h0, row_out[15]}, 32'h1);
        check_rows("R4 other cols open", f, 16'h7FFF);
        f = '0; f[240] = 1'b1; f[0] = 1'b1; f[239] = 1'b1;
        shift_frame(f);
        pulse_xfer();
        cur_cfg = f;
        check_rows("R3 Y15X0 and Y0X0", f, 16'h0001);
        check("R3 rows 15 and 0", {16'h0, row_out}, 32'h8001);
        check_rows("R3 17th bit Y14X15", f, 16'h8000);
        check("R3 row14 only", {16'h0, row_out}, 32'h4000);
    endtask

    task automatic t_fan();
        logic [255:0] f = '0;
        f[1*16+5] = 1'b1; f[3*16+5] = 1'b1; f[9*16+5] = 1'b1;
        f[7*16+2] = 1'b1; f[7*16+11] = 1'b1;
        shift_frame(f);
        pulse_xfer();
        cur_cfg = f;
        check_rows("R7 fan-out col5", f, 16'h0020);
        check("R7 rows 1,3,9", {16'h0, row_out}, 32'h020A);
        check_rows("R7 fan-in col2", f, 16'h0004);
        check_rows("R7 fan-in col11", f, 16'h0800);
        check_rows("R8 open rows low", f, 16'hFFFF);
        check("R8 open rows", {16'h0, row_out}, 32'h028A);
        check_rows("R4 no cols", f, 16'h0000);
    endtask

    task automatic t_hold_low();
        logic [255:0] f = '0;
        f[12*16 +: 16] = 16'hA5A5;
        f[4*16 +: 16]  = 16'h0F00;
        xfer_n = 1'b0;
        wait_cyc(4);
        shift_frame(f);
        check_rows("R5 shift during low keeps latches", cur_cfg, 16'hFFFF);
        check("R2 rows unchanged", {16'h0, row_out}, 32'h028A);
        xfer_n = 1'b1;
        wait_cyc(6);
        cur_cfg = f;
        check_rows("R5 release loads newest", f, 16'h0500);
        check_rows("R5 release loads newest b", f, 16'hFFFF);
        shift_frame(~f);
        check_rows("R5 hold after new shift", f, 16'hFFFF);
    endtask

    task automatic t_tail();
        logic [255:0] f = '0;
        f[255] = 1'b1; f[254] = 1'b0; f[253] = 1'b1;
        shift_frame(f);
        check("R6 tail after full frame", {31'h0, ser_out}, 32'h1);
        shift_bit(1'b0);
        check("R6 tail second bit", {31'h0, ser_out}, 32'h0);
        ser_clk = 1'b1; wait_cyc(5);
        ser_clk = 1'b0; wait_cyc(5);
        check("R6 tail third bit", {31'h0, ser_out}, 32'h1);
        wait_cyc(10);
        check("R6 no shift on fall/idle", {31'h0, ser_out}, 32'h1);
    endtask

    task automatic t_random();
        logic [255:0] f;
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 256; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                f[i] = lfsr[0] & lfsr[5];
            end
            shift_frame(f);
            pulse_xfer();
            cur_cfg = f;
            check_rows("R4 pattern a", f, lfsr[15:0]);
            check_rows("R4 pattern b", f, lfsr[31:16]);
            check_rows("R4 single col", f, 16'h0001 << k);
        end
    endtask

    initial begin
        fork
            begin
                wait_cyc(3);
                rst_n = 1'b1;
                wait_cyc(2);
                t_reset();
                t_order();
                t_fan();
                t_hold_low();
                t_tail();
                t_random();
            end
            begin
                wait_cyc(150000);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule